// File: doc/BRIEF.md
# Pipelined Load/Store Execute Stage

This block is the memory execute stage of an out-of-order integer core. It accepts decoded load and store instructions, each carrying two address operands, store data, a micro-op code and bookkeeping tags: a sequence number, a destination register index and two physical register tags. The instructions enter a small input queue. From the head of that queue, stage one adds the operands, clears the two low address bits and sends a word request to memory over a valid/ready port. For partial-word stores it moves the data onto the addressed byte lanes and drives a byte-enable mask.

Each request leaves a metadata entry behind in a power-of-two queue. The entry holds the byte offset, the micro-op and the tags. Memory answers in order. Stage two pairs each answer with the entry that sits in its awaited-response register, pulls out the addressed bytes, sign- or zero-extends them and presents a writeback record. When the metadata queue is empty and the holding register is free, a new entry skips the queue and goes straight into the register. With this path, a one-cycle memory answers in the cycle after the request. When answers arrive back to back, the register takes its next entry from the queue in the same cycle that the current answer is consumed.

Top module: `lsu_pipe`

## Requirements
- R1: The request address equals op1 + op2 (modulo 2^32) with bits 1:0 forced to zero. The request write flag equals micro-op bit 3, which is 1 for stores and 0 for loads.
- R2: The byte-enable mask takes its base from micro-op bits 1:0: 0 selects a byte (4'b0001), 1 selects a halfword (4'b0011) and 2 selects a word (4'b1111). The base is shifted left by the effective address bits 1:0 and cut to 4 bits. Every request carries a mask with one, two or four bits set.
- R3: The request write data is the instruction's store data shifted left by 8 × (effective address bits 1:0), cut to 32 bits.
- R4: A request is offered only while the input queue holds an instruction and the metadata queue is not full. An offered request that is not accepted stays offered in the next cycle, with address, mask, data and write flag unchanged.
- R5: The metadata queue holds IN_FLIGHT rounded up to a power of two entries, with a minimum of 2. With the default IN_FLIGHT = 3, exactly 5 requests can be outstanding without a response. No further request is offered until a response is consumed.
- R6: When the unit is idle, a request accepted in cycle c whose response arrives in cycle c+1 produces its writeback record in cycle c+1, provided the writeback output is ready.
- R7: When responses keep arriving and the writeback output stays ready, queued requests complete on consecutive cycles with no gap cycle.
- R8: For loads, the response word is shifted right by 8 × byte offset. Micro-op bit 2 = 0 sign-extends a byte or halfword result, and bit 2 = 1 zero-extends it. A word load returns the word as it is. The micro-op codes are: 0000 signed byte, 0001 signed halfword, 0010 word, 0100 unsigned byte and 0101 unsigned halfword.
- R9: A store (1000 byte, 1001 halfword, 1010 word) produces a writeback record with write enable 0 and data 0, whatever the response data is. A load produces one with write enable 1.
- R10: The response ready output is high only while a response is awaited and the writeback output is ready. A writeback record is valid only while a response is present. Records leave in request order and carry that instruction's sequence number, destination index and both physical tags.
- R11: The input ready output is low while the input queue (IN_DEPTH entries) is full.
- R12: During and just after reset, input ready is high and request valid, writeback valid and response ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Input queue can accept |
| in_uop | input | 4 | Micro-op: bit 3 store, bit 2 unsigned, bits 1:0 size |
| in_op1 | input | 32 | Base operand |
| in_op2 | input | 32 | Offset operand |
| in_wdata | input | 32 | Store data, lane 0 aligned |
| in_seq | input | SEQ_W | Sequence number |
| in_waddr | input | RADDR_W | Destination register index |
| in_preg | input | PREG_W | Destination physical tag |
| in_ppreg | input | PREG_W | Previous physical tag |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Word-aligned address |
| mem_req_we | output | 1 | Write request |
| mem_req_wdata | output | 32 | Lane-positioned write data |
| mem_req_strb | output | 4 | Byte enables |
| mem_resp_valid | input | 1 | Memory response present |
| mem_resp_ready | output | 1 | Response consumed |
| mem_resp_data | input | 32 | Response word |
| wb_valid | output | 1 | Writeback record valid |
| wb_ready | input | 1 | Writeback consumer ready |
| wb_seq | output | SEQ_W | Sequence number |
| wb_waddr | output | RADDR_W | Destination register index |
| wb_wen | output | 1 | Register write enable |
| wb_data | output | 32 | Extended load data |
| wb_preg | output | PREG_W | Destination physical tag |
| wb_ppreg | output | PREG_W | Previous physical tag |

## Verification
The assertions check the following on every cycle. An offered request stays unchanged until it is accepted. The byte-enable mask has a legal shape. The count of outstanding requests never passes the metadata queue depth plus one. Response ready and writeback valid follow only from an awaited entry and the consumer's readiness. A bypassed entry occupies the holding register in the next cycle. Only the bench's scenarios can show that the data is right: lane placement, extension for each micro-op against a memory model, that store responses are ignored, and that the tags keep their order. The same applies to the one-cycle bypass latency, gap-free refill after a stall, and the exact stall point with five outstanding requests.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;

  localparam int UOP_W     = 4;
  localparam int UOP_STORE = 3;
  localparam int UOP_UNS   = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  function automatic logic [31:0] eff_addr(input logic [31:0] a, input logic [31:0] b);
    return a + b;
  endfunction

  function automatic logic [31:0] word_align(input logic [31:0] ea);
    return {ea[31:2], 2'b00};
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    logic [3:0] base;
    case (sz)
      SZ_BYTE: base = 4'b0001;
      SZ_HALF: base = 4'b0011;
      default: base = 4'b1111;
    endcase
    return base << off;
  endfunction

  function automatic logic [31:0] store_lanes(input logic [31:0] d, input logic [1:0] off);
    return d << {off, 3'b000};
  endfunction

  function automatic logic [31:0] load_extend(input logic [31:0] d, input logic [1:0] off,
                                              input logic uns, input logic [1:0] sz);
    logic [31:0] sh;
    sh = d >> {off, 3'b000};
    case (sz)
      SZ_BYTE: return uns ? {24'b0, sh[7:0]}  : {{24{sh[7]}}, sh[7:0]};
      SZ_HALF: return uns ? {16'b0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
      default: return sh;
    endcase
  endfunction

endpackage

// File: rtl/lsu_fifo.sv
`timescale 1ns/1ps
module lsu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW:0]  wp, rp;
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp[AW-1:0]] <= din;
  end

  assign dout  = store[rp[AW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
endmodule

// File: rtl/lsu_req_gen.sv
`timescale 1ns/1ps
module lsu_req_gen (
  input  logic [31:0] op1,
  input  logic [31:0] op2,
  input  logic [31:0] wdata,
  input  logic        is_store,
  input  logic [1:0]  size,
  output logic [31:0] addr,
  output logic [1:0]  off,
  output logic [3:0]  strb,
  output logic [31:0] lanes,
  output logic        we
);
  import lsu_pkg::*;

  logic [31:0] ea;

  always_comb begin
    ea    = eff_addr(op1, op2);
    off   = ea[1:0];
    addr  = word_align(ea);
    strb  = lane_mask(size, ea[1:0]);
    lanes = store_lanes(wdata, ea[1:0]);
    we    = is_store;
  end
endmodule

// File: rtl/lsu_stage2.sv
`timescale 1ns/1ps
module lsu_stage2 #(
  parameter int META_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [META_W-1:0] push_meta,
  input  logic              fifo_empty,
  input  logic [META_W-1:0] fifo_head,
  input  logic              done,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic              bypass_take,
  output logic              s2_valid,
  output logic [META_W-1:0] s2_meta
);
  logic slot_free;

  always_comb begin
    slot_free   = !s2_valid || done;
    fifo_pop    = slot_free && !fifo_empty;
    bypass_take = slot_free && fifo_empty && push;
    fifo_push   = push && !bypass_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_meta  <= '0;
    end else if (slot_free) begin
      s2_valid <= fifo_pop || bypass_take;
      s2_meta  <= fifo_pop ? fifo_head : push_meta;
    end
  end
endmodule

// File: rtl/lsu_pipe.sv
`timescale 1ns/1ps
module lsu_pipe #(
  parameter int SEQ_W     = 8,
  parameter int RADDR_W   = 5,
  parameter int PREG_W    = 6,
  parameter int IN_DEPTH  = 2,
  parameter int IN_FLIGHT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [3:0]         in_uop,
  input  logic [31:0]        in_op1,
  input  logic [31:0]        in_op2,
  input  logic [31:0]        in_wdata,
  input  logic [SEQ_W-1:0]   in_seq,
  input  logic [RADDR_W-1:0] in_waddr,
  input  logic [PREG_W-1:0]  in_preg,
  input  logic [PREG_W-1:0]  in_ppreg,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [31:0]        mem_req_addr,
  output logic               mem_req_we,
  output logic [31:0]        mem_req_wdata,
  output logic [3:0]         mem_req_strb,
  input  logic               mem_resp_valid,
  output logic               mem_resp_ready,
  input  logic [31:0]        mem_resp_data,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [SEQ_W-1:0]   wb_seq,
  output logic [RADDR_W-1:0] wb_waddr,
  output logic               wb_wen,
  output logic [31:0]        wb_data,
  output logic [PREG_W-1:0]  wb_preg,
  output logic [PREG_W-1:0]  wb_ppreg
);
  import lsu_pkg::*;

  localparam int META_DEPTH = (IN_FLIGHT <= 2) ? 2 : (1 << $clog2(IN_FLIGHT));

  typedef struct packed {
    logic [3:0]         uop;
    logic [31:0]        op1;
    logic [31:0]        op2;
    logic [31:0]        wdata;
    logic [SEQ_W-1:0]   seq;
    logic [RADDR_W-1:0] waddr;
    logic [PREG_W-1:0]  preg;
    logic [PREG_W-1:0]  ppreg;
  } instr_t;

  typedef struct packed {
    logic [1:0]         off;
    logic [3:0]         uop;
    logic [SEQ_W-1:0]   seq;
    logic [RADDR_W-1:0] waddr;
    logic [PREG_W-1:0]  preg;
    logic [PREG_W-1:0]  ppreg;
  } meta_t;

  localparam int INSTR_W = $bits(instr_t);
  localparam int META_W  = $bits(meta_t);

  // named internal events for the checker
  logic   in_empty, in_full, head_valid, meta_space, req_fire, resp_done;
  logic   meta_empty, meta_full, meta_push, meta_pop, bypass_take, s2_valid;
  instr_t in_rec, head;
  meta_t  req_meta, meta_head, s2_meta;
  logic [1:0] req_off;

  assign in_rec = '{uop: in_uop, op1: in_op1, op2: in_op2, wdata: in_wdata,
                    seq: in_seq, waddr: in_waddr, preg: in_preg, ppreg: in_ppreg};

  lsu_fifo #(.W(INSTR_W), .DEPTH(IN_DEPTH)) u_in_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid && !in_full),
    .din   (in_rec),
    .pop   (req_fire),
    .dout  (head),
    .empty (in_empty),
    .full  (in_full)
  );

  assign in_ready   = !in_full;
  assign head_valid = !in_empty;
  assign meta_space = !meta_full;

  lsu_req_gen u_req (
    .op1      (head.op1),
    .op2      (head.op2),
    .wdata    (head.wdata),
    .is_store (head.uop[UOP_STORE]),
    .size     (head.uop[1:0]),
    .addr     (mem_req_addr),
    .off      (req_off),
    .strb     (mem_req_strb),
    .lanes    (mem_req_wdata),
    .we       (mem_req_we)
  );

  assign mem_req_valid = head_valid && meta_space;
  assign req_fire      = mem_req_valid && mem_req_ready;

  assign req_meta = '{off: req_off, uop: head.uop, seq: head.seq, waddr: head.waddr,
                      preg: head.preg, ppreg: head.ppreg};

  lsu_fifo #(.W(META_W), .DEPTH(META_DEPTH)) u_meta_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (meta_push),
    .din   (req_meta),
    .pop   (meta_pop),
    .dout  (meta_head),
    .empty (meta_empty),
    .full  (meta_full)
  );

  lsu_stage2 #(.META_W(META_W)) u_s2 (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (req_fire),
    .push_meta   (req_meta),
    .fifo_empty  (meta_empty),
    .fifo_head   (meta_head),
    .done        (resp_done),
    .fifo_push   (meta_push),
    .fifo_pop    (meta_pop),
    .bypass_take (bypass_take),
    .s2_valid    (s2_valid),
    .s2_meta     (s2_meta)
  );

  assign mem_resp_ready = s2_valid && wb_ready;
  assign resp_done      = mem_resp_valid && mem_resp_ready;
  assign wb_valid       = s2_valid && mem_resp_valid;

  always_comb begin
    wb_seq   = s2_meta.seq;
    wb_waddr = s2_meta.waddr;
    wb_preg  = s2_meta.preg;
    wb_ppreg = s2_meta.ppreg;
    wb_wen   = !s2_meta.uop[UOP_STORE];
    wb_data  = s2_meta.uop[UOP_STORE] ? 32'b0
             : load_extend(mem_resp_data, s2_meta.off, s2_meta.uop[UOP_UNS], s2_meta.uop[1:0]);
  end
endmodule

// File: rtl/lsu_pipe_chk.sv
`timescale 1ns/1ps
module lsu_pipe_chk #(
  parameter int IN_FLIGHT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic [3:0]  mem_req_strb,
  input logic [31:0] mem_req_wdata,
  input logic        mem_req_we,
  input logic        mem_resp_valid,
  input logic        mem_resp_ready,
  input logic        wb_valid,
  input logic        wb_ready,
  input logic        s2_valid,
  input logic        bypass_take
);
  localparam int LIMIT = ((IN_FLIGHT <= 2) ? 2 : (1 << $clog2(IN_FLIGHT))) + 1;

  logic [7:0] outst;
  logic       rq_fire, rs_fire;

  assign rq_fire = mem_req_valid && mem_req_ready;
  assign rs_fire = mem_resp_valid && mem_resp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else        outst <= outst + {7'b0, rq_fire} - {7'b0, rs_fire};
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_strb) && $stable(mem_req_wdata) && $stable(mem_req_we));

  a_r2_strb_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(mem_req_strb) == 1 || $countones(mem_req_strb) == 2
                       || $countones(mem_req_strb) == 4));

  a_r5_outstanding_limit: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= LIMIT);

  a_r10_resp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_resp_ready |-> wb_ready && (outst != 0));

  a_r10_wb_needs_resp: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> mem_resp_valid && s2_valid);

  a_r6_bypass_fill: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_take |=> s2_valid);
endmodule

bind lsu_pipe lsu_pipe_chk #(.IN_FLIGHT(IN_FLIGHT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_req_strb   (mem_req_strb),
  .mem_req_wdata  (mem_req_wdata),
  .mem_req_we     (mem_req_we),
  .mem_resp_valid (mem_resp_valid),
  .mem_resp_ready (mem_resp_ready),
  .wb_valid       (wb_valid),
  .wb_ready       (wb_ready),
  .s2_valid       (s2_valid),
  .bypass_take    (bypass_take)
);

// File: tb/lsu_pipe_test.sv
`timescale 1ns/1ps
module lsu_pipe_test;
  localparam int SEQ_W = 8, RADDR_W = 5, PREG_W = 6;

  typedef struct packed {
    logic [3:0]  uop;
    logic [31:0] a, b, wd, addr;
    logic [3:0]  strb;
    logic [31:0] lanes, res;
  } vec_t;

  // uop: 1000 SB, 1001 SH, 1010 SW, 0000 LB, 0001 LH, 0010 LW, 0100 LBU, 0101 LHU
  localparam vec_t TBL [17] = '{
    '{4'hA, 32'h100, 32'h4,        32'h8899AABB, 32'h104, 4'hF, 32'h8899AABB, 32'h0},
    '{4'h8, 32'h100, 32'h9,        32'h000000F1, 32'h108, 4'h2, 32'h0000F100, 32'h0},
    '{4'h9, 32'h10A, 32'h0,        32'h00008234, 32'h108, 4'hC, 32'h82340000, 32'h0},
    '{4'h2, 32'h104, 32'h0,        32'h0,        32'h104, 4'hF, 32'h0,        32'h8899AABB},
    '{4'h0, 32'h100, 32'h5,        32'h0,        32'h104, 4'h2, 32'h0,        32'hFFFFFFAA},
    '{4'h4, 32'h100, 32'h6,        32'h0,        32'h104, 4'h4, 32'h0,        32'h00000099},
    '{4'h1, 32'h10A, 32'h0,        32'h0,        32'h108, 4'hC, 32'h0,        32'hFFFF8234},
    '{4'h5, 32'h108, 32'h0,        32'h0,        32'h108, 4'h3, 32'h0,        32'h0000F100},
    '{4'h0, 32'h109, 32'h0,        32'h0,        32'h108, 4'h2, 32'h0,        32'hFFFFFFF1},
    '{4'h4, 32'h10B, 32'h0,        32'h0,        32'h108, 4'h8, 32'h0,        32'h00000082},
    '{4'h1, 32'h104, 32'h0,        32'h0,        32'h104, 4'h3, 32'h0,        32'hFFFFAABB},
    '{4'h2, 32'h10C, 32'hFFFFFFF8, 32'h0,        32'h104, 4'hF, 32'h0,        32'h8899AABB},
    '{4'hA, 32'h107, 32'h1,        32'h12345678, 32'h108, 4'hF, 32'h12345678, 32'h0},
    '{4'h5, 32'h10A, 32'h0,        32'h0,        32'h108, 4'hC, 32'h0,        32'h00001234},
    '{4'h0, 32'h10B, 32'h0,        32'h0,        32'h108, 4'h8, 32'h0,        32'h00000012},
    '{4'h8, 32'h103, 32'h0,        32'h0000007F, 32'h100, 4'h8, 32'h7F000000, 32'h0},
    '{4'h2, 32'h100, 32'h0,        32'h0,        32'h100, 4'hF, 32'h0,        32'h7F000000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic               in_valid = 0, in_ready;
  logic [3:0]         in_uop = 0;
  logic [31:0]        in_op1 = 0, in_op2 = 0, in_wdata = 0;
  logic [SEQ_W-1:0]   in_seq = 0;
  logic [RADDR_W-1:0] in_waddr = 0;
  logic [PREG_W-1:0]  in_preg = 0, in_ppreg = 0;
  logic               mem_req_valid, mem_req_ready = 0, mem_req_we;
  logic [31:0]        mem_req_addr, mem_req_wdata;
  logic [3:0]         mem_req_strb;
  logic               mem_resp_valid = 0, mem_resp_ready;
  logic [31:0]        mem_resp_data = 0;
  logic               wb_valid, wb_ready = 0, wb_wen;
  logic [SEQ_W-1:0]   wb_seq;
  logic [RADDR_W-1:0] wb_waddr;
  logic [31:0]        wb_data;
  logic [PREG_W-1:0]  wb_preg, wb_ppreg;

  lsu_pipe uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  logic [31:0] mem [16];
  logic [31:0] rq_data [64];
  int          rq_due [64];
  int rq_head = 0, rq_tail = 0;

  logic [3:0]  s_uop [64];
  logic [31:0] s_a [64], s_b [64], s_wd [64], e_addr [64], e_lanes [64], e_res [64];
  logic [3:0]  e_strb [64];
  logic [7:0]  s_tag [64];
  int sq_n = 0, sq_idx = 0, req_idx = 0, wb_idx = 0, last_req_cyc = 0;
  int wb_cyc [64];
  int lat_mode = 0, rr_mode = 0, wr_mode = 0;
  bit resp_hold = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(input int i);
    if (lat_mode == 0) return 1;
    if (lat_mode == 1) return 1 + (i * 3) % 5;
    return 6;
  endfunction

  task automatic add_op(input vec_t v, input logic [7:0] tag);
    s_uop[sq_n] = v.uop;  s_a[sq_n] = v.a;  s_b[sq_n] = v.b;  s_wd[sq_n] = v.wd;
    e_addr[sq_n] = v.addr; e_strb[sq_n] = v.strb; e_lanes[sq_n] = v.lanes;
    e_res[sq_n] = v.res;   s_tag[sq_n] = tag;
    sq_n++;
  endtask

  task automatic new_test();
    sq_n = 0; sq_idx = 0; req_idx = 0; wb_idx = 0;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (sq_idx < sq_n) begin
      in_valid = 1;  in_uop = s_uop[sq_idx]; in_op1 = s_a[sq_idx];
      in_op2 = s_b[sq_idx]; in_wdata = s_wd[sq_idx]; in_seq = s_tag[sq_idx];
      in_waddr = s_tag[sq_idx][4:0]; in_preg = s_tag[sq_idx][5:0] + 6'd1;
      in_ppreg = 6'd63 - s_tag[sq_idx][5:0];
    end else begin
      in_valid = 0; in_uop = 0; in_op1 = 0; in_op2 = 0; in_wdata = 0;
    end
    mem_req_ready = (rr_mode == 0) ? 1'b1 : (rr_mode == 3) ? 1'b0 : (cyc % 3 != 0);
    wb_ready = (wr_mode == 0) ? 1'b1 : (wr_mode == 2) ? 1'b0 : (cyc % 4 != 1);
    if (rq_head != rq_tail && rq_due[rq_head % 64] <= cyc && !resp_hold) begin
      mem_resp_valid = 1; mem_resp_data = rq_data[rq_head % 64];
    end else begin
      mem_resp_valid = 0; mem_resp_data = 32'hDEADBEEF;
    end
    #1;
    if (in_valid && in_ready) sq_idx++;
    if (mem_req_valid && mem_req_ready) begin
      int i = req_idx;
      chk(mem_req_addr == e_addr[i] && mem_req_we == s_uop[i][3], "R1", "addr/we",
          {31'b0, mem_req_we, mem_req_addr}, {31'b0, s_uop[i][3], e_addr[i]});
      chk(mem_req_strb == e_strb[i], "R2", "strobe", 64'(mem_req_strb), 64'(e_strb[i]));
      chk(mem_req_wdata == e_lanes[i], "R3", "lane data", 64'(mem_req_wdata), 64'(e_lanes[i]));
      if (mem_req_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_req_strb[b]) mem[mem_req_addr[5:2]][8*b +: 8] = mem_req_wdata[8*b +: 8];
        rq_data[rq_tail % 64] = 32'hCAFE5A5A;
      end else begin
        rq_data[rq_tail % 64] = mem[mem_req_addr[5:2]];
      end
      rq_due[rq_tail % 64] = cyc + lat_of(i);
      rq_tail++;
      req_idx++;
      last_req_cyc = cyc;
    end
    if (mem_resp_valid && mem_resp_ready) rq_head++;
    if (wb_valid && wb_ready) begin
      int k = wb_idx;
      chk(wb_data == e_res[k], s_uop[k][3] ? "R9" : "R8", "wb data",
          64'(wb_data), 64'(e_res[k]));
      chk(wb_wen == !s_uop[k][3], "R9", "wen", 64'(wb_wen), 64'(!s_uop[k][3]));
      chk({wb_seq, wb_waddr, wb_preg, wb_ppreg} ==
          {s_tag[k], s_tag[k][4:0], s_tag[k][5:0] + 6'd1, 6'd63 - s_tag[k][5:0]},
          "R10", "tags", 64'({wb_seq, wb_waddr, wb_preg, wb_ppreg}),
          64'({s_tag[k], s_tag[k][4:0], s_tag[k][5:0] + 6'd1, 6'd63 - s_tag[k][5:0]}));
      wb_cyc[k] = cyc;
      wb_idx++;
    end
  endtask

  task automatic drain();
    int n = 0;
    while (wb_idx < sq_n && n < 3000) begin step(); n++; end
    chk(wb_idx == sq_n, "R10", "all records returned", 64'(wb_idx), 64'(sq_n));
    repeat (3) step();
  endtask

  function automatic vec_t lw(input logic [31:0] a, input logic [31:0] res);
    return '{4'h2, a, 32'h0, 32'h0, a, 4'hF, 32'h0, res};
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready && !mem_req_valid && !wb_valid && !mem_resp_ready, "R12", "in reset",
        {in_ready, mem_req_valid, wb_valid, mem_resp_ready}, 4'b1000);
    @(negedge clk);
    rst_n = 1;
    step();
    chk(in_ready && !mem_req_valid && !wb_valid && !mem_resp_ready, "R12", "after reset",
        {in_ready, mem_req_valid, wb_valid, mem_resp_ready}, 4'b1000);

    // table passes: R1 R2 R3 R8 R9 R10 under three timing patterns
    for (int pass = 0; pass < 3; pass++) begin
      for (int w = 0; w < 16; w++) mem[w] = 32'h0;
      new_test();
      lat_mode = pass; rr_mode = (pass == 1); wr_mode = (pass == 1);
      for (int i = 0; i < 17; i++) add_op(TBL[i], 8'(pass * 32 + i));
      drain();
    end
    lat_mode = 0; rr_mode = 0; wr_mode = 0;
    for (int w = 0; w < 16; w++) mem[w] = 32'h01010101 * w;

    // R6: bypass gives one-cycle latency from request to writeback
    new_test();
    add_op(lw(32'h114, 32'h05050505), 8'd100);
    drain();
    chk(wb_cyc[0] - last_req_cyc == 1, "R6", "bypass latency",
        64'(wb_cyc[0] - last_req_cyc), 64'd1);

    // R11 and R4: input queue fills while memory refuses requests
    new_test();
    rr_mode = 3;
    for (int i = 0; i < 3; i++) add_op(lw(32'h104 + 4 * i, 32'h01010101 * (1 + i)), 8'(110 + i));
    repeat (4) step();
    chk(!in_ready, "R11", "in_ready when full", 64'(in_ready), 64'd0);
    chk(sq_idx == 2, "R11", "accepted count", 64'(sq_idx), 64'd2);
    chk(mem_req_valid, "R4", "request offered", 64'(mem_req_valid), 64'd1);
    rr_mode = 0;
    drain();

    // R10: writeback stall blocks response consumption
    new_test();
    wr_mode = 2;
    add_op(lw(32'h120, 32'h08080808), 8'd120);
    repeat (6) step();
    chk(wb_valid && !mem_resp_ready && wb_idx == 0, "R10", "stall hold",
        {wb_valid, mem_resp_ready, 1'(wb_idx)}, 3'b100);
    wr_mode = 0;
    drain();

    // R5, R4, R7: outstanding limit then gap-free refill
    new_test();
    resp_hold = 1;
    for (int i = 0; i < 8; i++) add_op(lw(32'h100 + 4 * i, 32'h01010101 * i), 8'(130 + i));
    repeat (20) step();
    chk(req_idx == 5, "R5", "outstanding limit", 64'(req_idx), 64'd5);
    chk(!mem_req_valid, "R4", "no request without space", 64'(mem_req_valid), 64'd0);
    resp_hold = 0;
    drain();
    for (int k = 0; k < 7; k++)
      chk(wb_cyc[k + 1] == wb_cyc[k] + 1, "R7", "consecutive completion",
          64'(wb_cyc[k + 1] - wb_cyc[k]), 64'd1);

    report();
  end
endmodule